// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, based on its destination address alone. The receive path feeds in the address bytes one at a time, flagging the first byte with a start strobe. The filter then issues a single accept-or-reject verdict. It does four things with the address: it compares it with a programmable station address, it always accepts the all-ones broadcast address, it looks multicast addresses up in a 64-entry hash bitmap, and it applies promiscuous and accept-all-multicast overrides.

The hash index is taken from a running CRC-32 over the address bytes. The CRC is built while the bytes arrive, so no address buffer is needed. A small state machine controls the flow. It has three states: `ST_IDLE` waits for a start strobe, `ST_COLLECT` gathers the remaining address bytes, and `ST_DECIDE` presents the verdict for one cycle. Its transitions are:

- **take-first**: any state moves to `ST_COLLECT` on a start-flagged byte.
- **take-next**: `ST_COLLECT` stays in `ST_COLLECT` on a further byte that is not the last.
- **finish**: `ST_COLLECT` (or any state, when the address is one byte long) moves to `ST_DECIDE` on the last address byte.
- **release**: `ST_DECIDE` returns to `ST_IDLE` when no new start arrives.
- **hold**: `ST_COLLECT` waits in place on idle cycles.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `decision_valid_o` and `accept_o` are 0, and they stay 0 until a complete address has been received.
- R2: A unicast destination (bit 0 of the first byte is 0) is accepted only when all six bytes equal the station address. A difference in any byte, including the last one, rejects the frame.
- R3: The all-ones address FF:FF:FF:FF:FF:FF is always accepted, even with every mode bit at 0 and an empty bitmap. An address that differs from all-ones by a single bit is not treated as broadcast.
- R4: With `mcast_hash_en_i` at 1, a multicast destination is accepted exactly when `hash_map_i[k]` is 1. The index k is bits 31:26 of a CRC-32 register computed as follows:
  - the register starts at FFFFFFFF;
  - it is updated with the reflected polynomial EDB88320;
  - the six address bytes are fed in arrival order, each byte least significant bit first;
  - the register value is used without final inversion.
- R5: With `all_mcast_i` at 1, every multicast destination is accepted whatever the bitmap holds.
- R6: A non-broadcast multicast destination is rejected when both `all_mcast_i` and `mcast_hash_en_i` are 0, even if its bitmap bit is set.
- R7: With `promisc_i` at 1, every address is accepted.
- R8: `decision_valid_o` is 1 for exactly one cycle, in the cycle after the sixth address byte is taken. Idle cycles between address bytes only delay the verdict. The control inputs and the bitmap are sampled in the cycle of the sixth byte.
- R9: Bytes with `byte_valid_i` at 1 but no start strobe, arriving while idle, are ignored. A start strobe in the middle of an address discards the partial address and begins a new one.
- R10: A start-flagged byte that arrives in the verdict cycle begins a new address. It does not disturb the verdict being shown in that cycle.
- R11: The first address byte is compared with `station_addr_i[47:40]` and the last with `station_addr_i[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Marks the byte on `byte_i` as the first destination byte |
| byte_valid_i | input | 1 | `byte_i` carries an address byte this cycle |
| byte_i | input | 8 | Destination address byte |
| station_addr_i | input | 48 | Own station address, first byte in bits 47:40 |
| hash_map_i | input | 64 | Multicast hash bitmap |
| promisc_i | input | 1 | Accept every address |
| all_mcast_i | input | 1 | Accept every multicast address |
| mcast_hash_en_i | input | 1 | Enable the multicast hash lookup |
| decision_valid_o | output | 1 | One-cycle verdict strobe |
| accept_o | output | 1 | Verdict: 1 keeps the frame; valid only with the strobe |

## Verification
Two functions can fall in the same cycle: presenting a verdict and taking the first byte of the next address. The bench provokes this by driving the next start-flagged byte in exactly the cycle the previous address's verdict is shown. It then judges three things: the verdict of the first address must be the one computed for that address, the new address must get its own correct verdict six bytes later, and neither address's bytes may leak into the other's comparison or CRC.

// File: rtl/daf_pkg.sv
package daf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DECIDE
    } daf_state_e;

    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

    // One byte of reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  b);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/daf_crc_acc.sv
module daf_crc_acc
    import daf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        init,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_nx
);
    logic [31:0] crc_q;

    assign crc_nx = crc_step_byte(init ? CRC_SEED : crc_q, byte_in);

    always_ff @(posedge clk) begin
        if (!rst_n)  crc_q <= CRC_SEED;
        else if (en) crc_q <= crc_nx;
    end
endmodule

// File: rtl/daf_addr_cmp.sv
module daf_addr_cmp #(
    parameter int ADDR_BYTES = 6,
    parameter int CNT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    first,
    input  logic [CNT_W-1:0]        idx,
    input  logic [7:0]              byte_in,
    input  logic [ADDR_BYTES*8-1:0] station,
    output logic                    eq_nx,
    output logic                    ones_nx,
    output logic                    mcast_nx
);
    localparam int ADDR_W = ADDR_BYTES * 8;

    logic [7:0] st_bytes [ADDR_BYTES];
    logic       eq_q, ones_q, mcast_q;
    logic [7:0] st_sel;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
        assign st_bytes[g] = station[ADDR_W-1-8*g -: 8];
    end

    always_comb begin
        st_sel = 8'h00;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (idx == CNT_W'(k)) st_sel = st_bytes[k];
    end

    assign eq_nx    = (first ? 1'b1 : eq_q)   && (byte_in == st_sel);
    assign ones_nx  = (first ? 1'b1 : ones_q) && (byte_in == 8'hFF);
    assign mcast_nx = first ? byte_in[0] : mcast_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_q    <= 1'b0;
            ones_q  <= 1'b0;
            mcast_q <= 1'b0;
        end else if (en) begin
            eq_q    <= eq_nx;
            ones_q  <= ones_nx;
            mcast_q <= mcast_nx;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     byte_valid_i,
    input  logic [7:0]               byte_i,
    input  logic [ADDR_BYTES*8-1:0]  station_addr_i,
    input  logic [(1<<HASH_BITS)-1:0] hash_map_i,
    input  logic                     promisc_i,
    input  logic                     all_mcast_i,
    input  logic                     mcast_hash_en_i,
    output logic                     decision_valid_o,
    output logic                     accept_o
);
    localparam int CNT_W = $clog2(ADDR_BYTES + 1);

    daf_state_e         state_q, state_nx;
    logic [CNT_W-1:0]   cnt_q, cnt_eff;
    logic               accept_q, verdict;
    logic               first_w, take_w, fin_w;
    logic [31:0]        crc_nx;
    logic               eq_nx, ones_nx, mcast_nx;
    logic [HASH_BITS-1:0] hidx;

    assign first_w = start_i && byte_valid_i;
    assign take_w  = byte_valid_i && (start_i || state_q == ST_COLLECT);
    assign cnt_eff = first_w ? '0 : cnt_q;
    assign fin_w   = take_w && (cnt_eff == CNT_W'(ADDR_BYTES - 1));
    assign hidx    = crc_nx[31 -: HASH_BITS];

    daf_crc_acc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (take_w),
        .init    (first_w),
        .byte_in (byte_i),
        .crc_nx  (crc_nx)
    );

    daf_addr_cmp #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (take_w),
        .first    (first_w),
        .idx      (cnt_eff),
        .byte_in  (byte_i),
        .station  (station_addr_i),
        .eq_nx    (eq_nx),
        .ones_nx  (ones_nx),
        .mcast_nx (mcast_nx)
    );

    // Verdict for the address whose last byte is taken this cycle.
    always_comb begin
        if (promisc_i || ones_nx) verdict = 1'b1;
        else if (mcast_nx)        verdict = all_mcast_i || (mcast_hash_en_i && hash_map_i[hidx]);
        else                      verdict = eq_nx;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (take_w) state_nx = fin_w ? ST_DECIDE : ST_COLLECT;
            ST_COLLECT: if (take_w) state_nx = fin_w ? ST_DECIDE : ST_COLLECT;
            ST_DECIDE:  state_nx = take_w ? (fin_w ? ST_DECIDE : ST_COLLECT) : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            accept_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (take_w) cnt_q <= cnt_eff + CNT_W'(1);
            accept_q <= fin_w ? verdict : 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        decision_valid_o = (state_q == ST_DECIDE);
        accept_o         = decision_valid_o && accept_q;
    end
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int ADDR_BYTES = 6
) (
    input logic clk,
    input logic rst_n,
    input logic byte_valid_i,
    input logic promisc_i,
    input logic all_mcast_i,
    input logic mcast_hash_en_i,
    input logic fin_w,
    input logic eq_nx,
    input logic ones_nx,
    input logic mcast_nx,
    input logic decision_valid_o,
    input logic accept_o
);
    // R8: the strobe lasts one cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ADDR_BYTES > 1) && decision_valid_o |=> !decision_valid_o);

    // R8: a verdict always follows a taken byte
    p_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid_o |-> $past(byte_valid_i));

    // R7: promiscuous accepts
    p_promisc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        decision_valid_o && $past(promisc_i) |-> accept_o);

    // R3: broadcast accepted
    p_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fin_w && ones_nx |=> decision_valid_o && accept_o);

    // R2: unicast verdict follows the comparator
    p_unicast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fin_w && !mcast_nx && !promisc_i |=> accept_o == $past(eq_nx));

    // R6: multicast with no multicast mode is rejected
    p_no_mcast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_w && mcast_nx && !ones_nx && !promisc_i && !all_mcast_i && !mcast_hash_en_i
        |=> !accept_o);
endmodule

bind dst_addr_filter daf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_daf_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .byte_valid_i     (byte_valid_i),
    .promisc_i        (promisc_i),
    .all_mcast_i      (all_mcast_i),
    .mcast_hash_en_i  (mcast_hash_en_i),
    .fin_w            (fin_w),
    .eq_nx            (eq_nx),
    .ones_nx          (ones_nx),
    .mcast_nx         (mcast_nx),
    .decision_valid_o (decision_valid_o),
    .accept_o         (accept_o)
);

// File: tb/dst_addr_filter_bench.sv
module dst_addr_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam int NVEC = 13;

    // entry: addr[53:6], hash mode[5:4] (0 empty,1 only own bit,2 all but own,3 full),
    //        promisc[3], all_mcast[2], hash_en[1], expected[0]
    localparam logic [53:0] VEC [NVEC] = '{
        {48'h02_11_22_33_44_55, 2'd0, 3'b000, 1'b1},  // R2 R11 exact
        {48'h02_11_22_33_44_56, 2'd0, 3'b000, 1'b0},  // R2 last byte off
        {48'h06_11_22_33_44_55, 2'd0, 3'b000, 1'b0},  // R11 first byte off
        {48'hFF_FF_FF_FF_FF_FF, 2'd0, 3'b000, 1'b1},  // R3
        {48'h01_00_5E_00_00_01, 2'd1, 3'b001, 1'b1},  // R4 bit set
        {48'h01_00_5E_00_00_01, 2'd2, 3'b001, 1'b0},  // R4 bit clear
        {48'h01_00_5E_00_00_01, 2'd0, 3'b010, 1'b1},  // R5
        {48'h01_00_5E_00_00_01, 2'd3, 3'b000, 1'b0},  // R6
        {48'h0A_0B_0C_0D_0E_0F, 2'd0, 3'b100, 1'b1},  // R7
        {48'h33_33_00_00_00_01, 2'd1, 3'b000, 1'b0},  // R6
        {48'h33_33_00_00_00_01, 2'd1, 3'b001, 1'b1},  // R4
        {48'hFF_FF_FF_FF_FF_FE, 2'd0, 3'b000, 1'b0},  // R3 near-broadcast
        {48'hFF_FF_FF_FF_FF_FE, 2'd0, 3'b100, 1'b1}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0]  byte_i = 8'h00;
    logic [47:0] station_addr_i = STATION;
    logic [63:0] hash_map_i = '0;
    logic        promisc_i = 1'b0, all_mcast_i = 1'b0, mcast_hash_en_i = 1'b0;
    logic        decision_valid_o, accept_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_addr_filter u_dst_addr_filter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .station_addr_i(station_addr_i), .hash_map_i(hash_map_i),
        .promisc_i(promisc_i), .all_mcast_i(all_mcast_i),
        .mcast_hash_en_i(mcast_hash_en_i),
        .decision_valid_o(decision_valid_o), .accept_o(accept_o)
    );

    function automatic int hash_of(input logic [47:0] a);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int n = 0; n < 6; n++) begin
            logic [7:0] b;
            b = a[47-8*n -: 8];
            for (int i = 0; i < 8; i++)
                c = (c[0] ^ b[i]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return int'(c[31:26]);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic drive_byte(input logic st, input logic [7:0] b);
        @(negedge clk);
        start_i = st; byte_valid_i = 1'b1; byte_i = b;
    endtask

    task automatic go_idle;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, input bit gap, input int nbytes);
        for (int i = 0; i < nbytes; i++) begin
            if (gap && i > 0) go_idle();
            drive_byte(i == 0, a[47-8*i -: 8]);
        end
    endtask

    // Call right after the sixth byte was driven.
    task automatic expect_verdict(input string req, input logic exp);
        check({req, " early strobe"}, decision_valid_o, 1'b0);
        go_idle();
        check({req, " strobe"}, decision_valid_o, 1'b1);
        check({req, " verdict"}, accept_o, exp);
        @(negedge clk);
        check({req, " strobe width"}, decision_valid_o, 1'b0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", decision_valid_o, 1'b0);
        check("R1 accept in reset", accept_o, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", decision_valid_o, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            logic [47:0] a;
            int h;
            a = VEC[v][53:6];
            h = hash_of(a);
            unique case (VEC[v][5:4])
                2'd0: hash_map_i = '0;
                2'd1: hash_map_i = 64'd1 << h;
                2'd2: hash_map_i = ~(64'd1 << h);
                default: hash_map_i = '1;
            endcase
            promisc_i = VEC[v][3]; all_mcast_i = VEC[v][2]; mcast_hash_en_i = VEC[v][1];
            send(a, 1'b0, 6);
            expect_verdict($sformatf("vector %0d", v), VEC[v][0]);
        end
        hash_map_i = '0; promisc_i = 0; all_mcast_i = 0; mcast_hash_en_i = 0;

        // R8: idle gaps between bytes
        send(STATION, 1'b1, 6);
        expect_verdict("R8 gapped", 1'b1);

        // R9: bytes without start while idle are ignored
        for (int k = 0; k < 8; k++) begin
            drive_byte(1'b0, 8'hFF);
            check("R9 stray bytes", decision_valid_o, 1'b0);
        end
        go_idle();
        check("R9 stray bytes after", decision_valid_o, 1'b0);

        // R9: restart discards partial address
        send(48'h0A_0B_0C_0D_0E_0F, 1'b0, 3);
        send(STATION, 1'b0, 6);
        expect_verdict("R9 restart to match", 1'b1);
        send(STATION, 1'b0, 4);
        send(48'h02_11_22_33_44_99, 1'b0, 6);
        expect_verdict("R9 restart to mismatch", 1'b0);

        // R10: next start coincides with the verdict cycle
        send(STATION, 1'b0, 6);
        drive_byte(1'b1, 8'h02);
        check("R10 first strobe", decision_valid_o, 1'b1);
        check("R10 first verdict", accept_o, 1'b1);
        for (int i = 1; i < 6; i++) drive_byte(1'b0, (i == 5) ? 8'h54 : STATION[47-8*i -: 8]);
        expect_verdict("R10 second address", 1'b0);

        // R10 reversed: rejected first, accepted broadcast second
        send(48'h02_11_22_33_44_00, 1'b0, 6);
        drive_byte(1'b1, 8'hFF);
        check("R10 reject strobe", decision_valid_o, 1'b1);
        check("R10 reject verdict", accept_o, 1'b0);
        for (int i = 1; i < 6; i++) drive_byte(1'b0, 8'hFF);
        expect_verdict("R10 broadcast second", 1'b1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule